// File: doc/BRIEF.md
# Four-Phase Word Transfer Master

This block moves a message between a local word memory and a remote slave over a four-phase ready/ack bus with a 16-bit address and a 32-bit data path. A local agent pulses a start strobe together with a direction (write to the slave or read from it), a bus address and a byte count. The engine then repeats one complete handshake for each 32-bit word of the message. Every word of a message goes to the same bus address, and the local memory is walked one word index at a time, starting at zero.

For each word the master presents the address, and on writes also the data with the data enable asserted. After a programmed setup interval it raises ready. It keeps ready high until the slave answers with ack, then holds for a programmed interval that differs between writes and reads. It then lowers ready and waits for the slave to drop ack before it starts the next word. On reads the data bus is left undriven, and the incoming word is stored into local memory in the same cycle that ack is first seen high. The setup and hold intervals are parameters counted in clock cycles. At elaboration they are converted to nanoseconds and checked against the permitted timing windows.

Top module: `dhs_master`

## Requirements
- R1: After reset, req_busy, req_done, bus_ready, bus_doe and mem_we are all low.
- R2: On a write word, the word read from local memory appears on bus_dout with bus_doe high for exactly SETUP_CYC clock cycles before bus_ready rises.
- R3: Once bus_ready is high it stays high until bus_ack is sampled high. It then falls exactly HOLD_WR_CYC (write) or HOLD_RD_CYC (read) cycles after the clock edge at which ack was first sampled high. While ack stays high after that, ready remains low and no new word begins.
- R4: On a read word, bus_doe stays low for the whole message. The value on bus_din at the edge where ack is first sampled high is written, with mem_we, to local memory at the current word index.
- R5: A message of N bytes is carried as ceil(N/4) words, which use memory word indexes 0, 1, 2 and so on in order. bus_addr holds the requested address for every word of the message.
- R6: A start with a byte count of zero produces req_done in the cycle after the start is accepted, and bus_ready never rises.
- R7: A start pulse while req_busy is high is ignored: it changes neither the address, the direction nor the length of the running message, and it starts no message afterwards.
- R8: req_done is a single-cycle pulse. It comes once per message, in the cycle after ack is seen low for the last word. req_busy is high from the cycle after acceptance up to and including the req_done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | Start strobe for a message, taken only when idle |
| req_read | input | 1 | 1 = read words from the slave, 0 = write words to it |
| req_addr | input | 16 | Bus address used for every word of the message |
| req_bytes | input | BYTES_W (8) | Message length in bytes |
| req_busy | output | 1 | A message is in progress |
| req_done | output | 1 | One-cycle completion pulse |
| mem_idx | output | BYTES_W-1 (7) | Local memory word index |
| mem_rdata | input | 32 | Local memory read data, combinational on mem_idx |
| mem_we | output | 1 | Local memory write strobe (reads from the bus) |
| mem_wdata | output | 32 | Local memory write data |
| bus_addr | output | 16 | Bus address |
| bus_dout | output | 32 | Data driven to the bus on writes |
| bus_doe | output | 1 | Data output enable, high only during write words |
| bus_din | input | 32 | Data bus as seen by the master |
| bus_ready | output | 1 | Master request strobe |
| bus_ack | input | 1 | Slave acknowledge |

## Verification
A faulty phase register shows at the bus within one word. Ready either rises early with respect to the data enable or falls after the wrong number of cycles, so the setup and hold counts measured at the ports differ from the programmed values on the very first handshake. A faulty word counter or index shows only at the end of a message: the number of handshakes differs, or a read word lands in the wrong memory slot, or the completion pulse arrives early or late. For that reason the multi-word scenarios compare every logged word and every memory slot once the message has finished.

// File: rtl/dhs_pkg.sv
package dhs_pkg;

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_LOAD    = 3'd1,
    PH_SETUP   = 3'd2,
    PH_WAIT_HI = 3'd3,
    PH_HOLD    = 3'd4,
    PH_WAIT_LO = 3'd5,
    PH_FIN     = 3'd6
  } phase_t;

  // Number of 32-bit words covering a byte count (rounded up).
  function automatic int unsigned words_for_bytes(input int unsigned nbytes);
    return (nbytes + 32'd3) >> 2;
  endfunction

  // True when a cycle count times the clock period lies inside [lo, hi] ns.
  function automatic bit in_window(input int unsigned cycles,
                                   input int unsigned clk_ns,
                                   input int unsigned lo,
                                   input int unsigned hi);
    return (cycles * clk_ns >= lo) && (cycles * clk_ns <= hi);
  endfunction

  // Largest of three values, used to size the interval counter.
  function automatic int unsigned max3(input int unsigned a,
                                       input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/dhs_timer.sv
module dhs_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

  AST_TIMER_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !expired) |=> (cnt_q == $past(cnt_q) - 1'b1)) else $error("timer"); // R3

endmodule

// File: rtl/dhs_slicer.sv
module dhs_slicer #(
  parameter int BYTES_W = 8,
  localparam int IDX_W  = BYTES_W - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               init,
  input  logic [BYTES_W-1:0] nbytes,
  input  logic               step,
  output logic [IDX_W-1:0]   word_idx,
  output logic               last_word,
  output logic               zero_len
);
  import dhs_pkg::*;

  logic [IDX_W-1:0] left_q;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] words_req;

  assign words_req = IDX_W'(words_for_bytes(32'(nbytes)));
  assign zero_len  = (nbytes == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      idx_q  <= '0;
    end else if (init) begin
      left_q <= words_req;
      idx_q  <= '0;
    end else if (step) begin
      left_q <= left_q - 1'b1;
      idx_q  <= idx_q + 1'b1;
    end
  end

  assign word_idx  = idx_q;
  assign last_word = (left_q == IDX_W'(1));

  AST_STEP_HAS_WORDS: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (left_q > IDX_W'(1))) else $error("step past end"); // R5

endmodule

// File: rtl/dhs_phase_fsm.sv
module dhs_phase_fsm #(
  parameter int TMR_W   = 4,
  parameter int SETUP_CYC   = 2,
  parameter int HOLD_WR_CYC = 3,
  parameter int HOLD_RD_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_start,
  input  logic              zero_len,
  input  logic              dir_rd,
  input  logic              bus_ack,
  input  logic              tmr_expired,
  input  logic              last_word,
  output dhs_pkg::phase_t   phase,
  output logic              accept,
  output logic              tmr_load,
  output logic [TMR_W-1:0]  tmr_val,
  output logic              word_step,
  output logic              ack_seen
);
  import dhs_pkg::*;

  phase_t ph_q, ph_d;

  assign phase = ph_q;

  always_comb begin
    ph_d      = ph_q;
    accept    = 1'b0;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    word_step = 1'b0;
    ack_seen  = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (req_start) begin
          accept = 1'b1;
          ph_d   = zero_len ? PH_FIN : PH_LOAD;
        end
      end
      PH_LOAD: begin
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(SETUP_CYC - 1);
        ph_d     = PH_SETUP;
      end
      PH_SETUP: begin
        if (tmr_expired) ph_d = PH_WAIT_HI;
      end
      PH_WAIT_HI: begin
        if (bus_ack) begin
          ack_seen = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = dir_rd ? TMR_W'(HOLD_RD_CYC - 1) : TMR_W'(HOLD_WR_CYC - 1);
          ph_d     = PH_HOLD;
        end
      end
      PH_HOLD: begin
        if (tmr_expired) ph_d = PH_WAIT_LO;
      end
      PH_WAIT_LO: begin
        if (!bus_ack) begin
          if (last_word) begin
            ph_d = PH_FIN;
          end else begin
            word_step = 1'b1;
            ph_d      = PH_LOAD;
          end
        end
      end
      PH_FIN: ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else        ph_q <= ph_d;
  end

  AST_FIN_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_FIN) |=> (ph_q == PH_IDLE)) else $error("fin"); // R8
  AST_WAIT_LO_NEEDS_ACK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ((ph_q == PH_WAIT_LO) && bus_ack) |=> (ph_q == PH_WAIT_LO)) else $error("wait lo"); // R3

endmodule

// File: rtl/dhs_master.sv
module dhs_master #(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32,
  parameter int BYTES_W     = 8,
  parameter int CLK_NS      = 4,
  parameter int SETUP_CYC   = 2,
  parameter int HOLD_WR_CYC = 3,
  parameter int HOLD_RD_CYC = 4,
  parameter int SETUP_MIN_NS = 5,
  parameter int SETUP_MAX_NS = 15,
  parameter int HOLD_MIN_NS  = 10,
  parameter int HOLD_MAX_NS  = 25,
  localparam int IDX_W = BYTES_W - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_start,
  input  logic               req_read,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [BYTES_W-1:0] req_bytes,
  output logic               req_busy,
  output logic               req_done,
  output logic [IDX_W-1:0]   mem_idx,
  input  logic [DATA_W-1:0]  mem_rdata,
  output logic               mem_we,
  output logic [DATA_W-1:0]  mem_wdata,
  output logic [ADDR_W-1:0]  bus_addr,
  output logic [DATA_W-1:0]  bus_dout,
  output logic               bus_doe,
  input  logic [DATA_W-1:0]  bus_din,
  output logic               bus_ready,
  input  logic               bus_ack
);
  import dhs_pkg::*;

  localparam int TMR_MAX = int'(max3(SETUP_CYC, HOLD_WR_CYC, HOLD_RD_CYC));
  localparam int TMR_W   = $clog2(TMR_MAX + 1);

  generate
    if (!in_window(SETUP_CYC, CLK_NS, SETUP_MIN_NS, SETUP_MAX_NS)) begin : g_bad_setup
      $error("SETUP_CYC outside allowed setup window");
    end
    if (!in_window(HOLD_WR_CYC, CLK_NS, HOLD_MIN_NS, HOLD_MAX_NS)) begin : g_bad_hold_wr
      $error("HOLD_WR_CYC outside allowed hold window");
    end
    if (!in_window(HOLD_RD_CYC, CLK_NS, HOLD_MIN_NS, HOLD_MAX_NS)) begin : g_bad_hold_rd
      $error("HOLD_RD_CYC outside allowed hold window");
    end
  endgenerate

  // Named internal events
  phase_t             phase;
  logic               accept;
  logic               tmr_load;
  logic [TMR_W-1:0]   tmr_val;
  logic               tmr_expired;
  logic               word_step;
  logic               ack_seen;
  logic               last_word;
  logic               zero_len;
  logic               setup_done;
  logic               hold_done;

  logic               dir_rd_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [DATA_W-1:0]  dout_q;

  dhs_slicer #(.BYTES_W(BYTES_W)) u_slicer (
    .clk      (clk),
    .rst_n    (rst_n),
    .init     (accept),
    .nbytes   (req_bytes),
    .step     (word_step),
    .word_idx (mem_idx),
    .last_word(last_word),
    .zero_len (zero_len)
  );

  dhs_timer #(.W(TMR_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .load_val(tmr_val),
    .expired (tmr_expired)
  );

  dhs_phase_fsm #(
    .TMR_W      (TMR_W),
    .SETUP_CYC  (SETUP_CYC),
    .HOLD_WR_CYC(HOLD_WR_CYC),
    .HOLD_RD_CYC(HOLD_RD_CYC)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_start  (req_start),
    .zero_len   (zero_len),
    .dir_rd     (dir_rd_q),
    .bus_ack    (bus_ack),
    .tmr_expired(tmr_expired),
    .last_word  (last_word),
    .phase      (phase),
    .accept     (accept),
    .tmr_load   (tmr_load),
    .tmr_val    (tmr_val),
    .word_step  (word_step),
    .ack_seen   (ack_seen)
  );

  assign setup_done = (phase == PH_SETUP) && tmr_expired;
  assign hold_done  = (phase == PH_HOLD)  && tmr_expired;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_rd_q <= 1'b0;
      addr_q   <= '0;
    end else if (accept) begin
      dir_rd_q <= req_read;
      addr_q   <= req_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  dout_q <= '0;
    else if (phase == PH_LOAD)   dout_q <= mem_rdata;
  end

  assign bus_addr  = addr_q;
  assign bus_dout  = dout_q;
  assign bus_ready = (phase == PH_WAIT_HI) || (phase == PH_HOLD);
  assign bus_doe   = !dir_rd_q &&
                     ((phase == PH_SETUP) || (phase == PH_WAIT_HI) ||
                      (phase == PH_HOLD)  || (phase == PH_WAIT_LO));
  assign mem_we    = dir_rd_q && ack_seen;
  assign mem_wdata = bus_din;
  assign req_busy  = (phase != PH_IDLE);
  assign req_done  = (phase == PH_FIN);

  AST_READY_AFTER_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_ready) |-> $past(setup_done)) else $error("ready early"); // R2
  AST_READY_FALL_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_ready) |-> $past(hold_done)) else $error("ready fell early"); // R3
  AST_READ_BUS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_busy && dir_rd_q) |-> !bus_doe) else $error("doe on read"); // R4
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_busy && $past(req_busy)) |-> $stable(bus_addr)) else $error("addr moved"); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |=> !req_done) else $error("done stuck"); // R8
  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
    (req_busy && req_start) |-> !accept) else $error("start taken while busy"); // R7

endmodule

// File: tb/dhs_master_tb.sv
module dhs_master_tb_top;

  localparam int SU = 2;
  localparam int HW = 3;
  localparam int HR = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_start = 1'b0;
  logic        req_read = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_bytes = '0;
  logic        req_busy, req_done;
  logic [6:0]  mem_idx;
  logic [31:0] mem_rdata;
  logic        mem_we;
  logic [31:0] mem_wdata;
  logic [15:0] bus_addr;
  logic [31:0] bus_dout;
  logic        bus_doe;
  logic [31:0] bus_din = '0;
  logic        bus_ready;
  logic        bus_ack = 1'b0;

  int total = 0;
  int bad = 0;

  logic [31:0] mem [0:63];
  logic [31:0] slv_data [0:63];
  logic [15:0] slv_addr [0:63];
  int slv_cnt = 0;
  int ack_lat = 0;
  int rel_lat = 0;
  bit exp_rd = 1'b0;
  int rd_doe_cnt = 0;
  int ready_cnt = 0;

  always #2 clk = ~clk;

  dhs_master #(.SETUP_CYC(SU), .HOLD_WR_CYC(HW), .HOLD_RD_CYC(HR)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_start(req_start), .req_read(req_read), .req_addr(req_addr),
    .req_bytes(req_bytes), .req_busy(req_busy), .req_done(req_done),
    .mem_idx(mem_idx), .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_doe(bus_doe),
    .bus_din(bus_din), .bus_ready(bus_ready), .bus_ack(bus_ack)
  );

  assign mem_rdata = mem[mem_idx[5:0]];
  always @(posedge clk) if (mem_we) mem[mem_idx[5:0]] <= mem_wdata;

  always @(negedge clk) begin
    if (exp_rd && bus_doe) rd_doe_cnt <= rd_doe_cnt + 1;
    if (bus_ready) ready_cnt <= ready_cnt + 1;
  end

  function automatic logic [31:0] pat(input int k);
    return 32'hC0DE_0000 ^ (32'(k) * 32'h0001_0203);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Slave model: measures setup and hold at the ports, logs each word.
  initial begin : slave
    int su_cnt;
    int hc;
    int early;
    su_cnt = 0;
    forever begin
      @(negedge clk);
      if (!bus_ready) begin
        su_cnt = bus_doe ? su_cnt + 1 : 0;
      end else begin
        if (!exp_rd) check(su_cnt == SU, "R2 setup cycles", su_cnt, SU);
        slv_addr[slv_cnt] = bus_addr;
        slv_data[slv_cnt] = bus_dout;
        early = 0;
        for (int i = 0; i < ack_lat; i++) begin
          @(negedge clk);
          if (!bus_ready) early++;
        end
        check(early == 0, "R3 ready held until ack", early, 0);
        bus_din = pat(slv_cnt);
        bus_ack = 1'b1;
        hc = 0;
        @(negedge clk);
        while (bus_ready) begin
          hc++;
          @(negedge clk);
        end
        check(hc == (exp_rd ? HR : HW), "R3 hold cycles", hc, exp_rd ? HR : HW);
        early = 0;
        for (int i = 0; i < rel_lat; i++) begin
          @(negedge clk);
          if (bus_ready || req_done) early++;
        end
        check(early == 0, "R3 waits for ack low", early, 0);
        bus_ack = 1'b0;
        su_cnt = 0;
        slv_cnt++;
      end
    end
  end

  task automatic run_msg(input bit rd, input logic [15:0] a, input logic [7:0] n,
                         input bit poke_busy);
    int dn;
    int guard;
    slv_cnt = 0;
    exp_rd = rd;
    @(negedge clk);
    req_start = 1'b1; req_read = rd; req_addr = a; req_bytes = n;
    @(negedge clk);
    req_start = 1'b0;
    dn = 0;
    guard = 0;
    while (req_busy && guard < 5000) begin
      if (req_done) dn++;
      if (poke_busy && guard == 3) begin
        req_start = 1'b1; req_read = ~rd; req_addr = 16'hBEEF; req_bytes = 8'd40;
      end else begin
        req_start = 1'b0;
      end
      @(negedge clk);
      guard++;
    end
    req_start = 1'b0;
    check(dn == 1, "R8 one done pulse", dn, 1);
  endtask

  task automatic t_reset();
    check(!req_busy && !req_done, "R1 reset idle", {req_busy, req_done}, 0);
    check(!bus_ready && !bus_doe && !mem_we, "R1 reset bus", {bus_ready, bus_doe, mem_we}, 0);
  endtask

  task automatic t_write(input logic [15:0] a, input logic [7:0] n, input int al, input int rl);
    int nw;
    ack_lat = al; rel_lat = rl;
    for (int i = 0; i < 64; i++) mem[i] = 32'h1000_0000 + 32'(i) * 32'h0101;
    nw = (int'(n) + 3) / 4;
    run_msg(1'b0, a, n, 1'b0);
    check(slv_cnt == nw, "R5 word count", slv_cnt, nw);
    for (int k = 0; k < nw; k++) begin
      check(slv_data[k] == mem[k], "R2 write data", slv_data[k], mem[k]);
      check(slv_addr[k] == a, "R5 same address", 32'(slv_addr[k]), 32'(a));
    end
  endtask

  task automatic t_read(input logic [15:0] a, input logic [7:0] n, input int al, input int rl);
    int nw;
    ack_lat = al; rel_lat = rl;
    for (int i = 0; i < 64; i++) mem[i] = 32'hDEAD_0000;
    rd_doe_cnt = 0;
    nw = (int'(n) + 3) / 4;
    run_msg(1'b1, a, n, 1'b0);
    check(slv_cnt == nw, "R5 read word count", slv_cnt, nw);
    check(rd_doe_cnt == 0, "R4 data bus released", rd_doe_cnt, 0);
    for (int k = 0; k < nw; k++)
      check(mem[k] == pat(k), "R4 read data stored", mem[k], pat(k));
    check(mem[nw] == 32'hDEAD_0000, "R4 no extra store", mem[nw], 32'hDEAD_0000);
  endtask

  task automatic t_zero();
    int rc;
    rc = ready_cnt;
    @(negedge clk);
    req_start = 1'b1; req_read = 1'b0; req_addr = 16'h0042; req_bytes = 8'd0;
    @(negedge clk);
    req_start = 1'b0;
    check(req_done && req_busy, "R6 zero length done", {req_done, req_busy}, 2'b11);
    @(negedge clk);
    check(!req_done && !req_busy, "R8 done single pulse", {req_done, req_busy}, 0);
    repeat (5) @(negedge clk);
    check(ready_cnt == rc, "R6 no bus activity", ready_cnt - rc, 0);
  endtask

  task automatic t_busy_ignore();
    int rc;
    ack_lat = 1; rel_lat = 1;
    for (int i = 0; i < 64; i++) mem[i] = 32'h5A00_0000 + 32'(i);
    run_msg(1'b0, 16'h1234, 8'd8, 1'b1);
    check(slv_cnt == 2, "R7 length unchanged", slv_cnt, 2);
    check(slv_addr[1] == 16'h1234, "R7 address unchanged", 32'(slv_addr[1]), 32'h1234);
    check(slv_data[1] == mem[1], "R7 direction unchanged", slv_data[1], mem[1]);
    rc = ready_cnt;
    repeat (20) @(negedge clk);
    check(ready_cnt == rc && !req_busy, "R7 no later message", ready_cnt - rc, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_write(16'hA001, 8'd8, 0, 0);
    t_write(16'h7F10, 8'd6, 3, 2);
    t_write(16'h0004, 8'd4, 1, 4);
    t_read(16'h3C3C, 8'd12, 2, 1);
    t_read(16'hFFFF, 8'd1, 0, 0);
    t_zero();
    t_busy_ignore();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule